// File: doc/BRIEF.md
# Drawing Command Packet Parser

The parser sits between a command word source and a drawing engine. It takes 32-bit words over a valid/ready interface and finds packet boundaries. The top byte of the first word of each packet is the opcode, and a decode function gives the packet length for each opcode. Once a packet has fully arrived, the parser applies its side effects and then passes the packet on to the renderer as a word stream. The final word of that stream carries a last flag.

Two opcode groups act on the parser's own state. The environment group writes one of eight 32-bit environment registers. The textured primitive families quietly replace the texture-page field of environment register 1 with a value taken from a word inside the packet. A 13-bit status word follows environment registers 1 and 6. Packets that set up a frame-memory transfer are not sent to the renderer. Instead they give a rectangle to a transfer engine. A write setup then sends every following input word directly to that engine until the engine reports that it is done.

Top module: `pkt_parser`

## Requirements
- R1: Packet length is one word plus an extra count chosen by the opcode (bits [31:24] of the first word). The extra count is 2 for 0x02, 0x40–43, 0x60–63, 0x6C–6F, 0x70–73, 0x7C–7F, 0xA0 and 0xC0. It is 3 for 0x20–23, 0x48–53, 0x64–67, 0x74–77 and 0x80. It is 4 for 0x28–2B and 0x58–5F, and 5 for 0x30–33. It is 6 for 0x24–27, 7 for 0x38–3B, 8 for 0x2C–2F and 0x34–37, 11 for 0x3C–3F, and 1 for 0x68–6B and 0x78–7B. Every packet that is not a transfer setup is forwarded in the order it arrived, with `pkt_last_o` high only on its final word.
- R2: Any opcode not listed in R1 (for example 0x00, 0x44, 0xE1) forms a one-word packet.
- R3: The parser forwards nothing and changes no register until every word of a packet has arrived. Gaps between input words are allowed. The input is not accepted while a packet is being forwarded.
- R4: Opcodes 0xE0–0xE7 copy the whole word into environment register opcode[2:0]. These packets are also forwarded.
- R5: When (opcode & 0xF4) == 0x24, bits [8:0] of environment register 1 take bits [8:0] of packet word 4. Its other bits stay unchanged.
- R6: When (opcode & 0xF4) == 0x34, bits [8:0] of environment register 1 take bits [8:0] of packet word 5.
- R7: `status_o[10:0]` always equals environment register 1 bits [10:0], and `status_o[12:11]` always equals environment register 6 bits [1:0].
- R8: Opcodes 0xA0 (write) and 0xC0 (read) are not forwarded. They raise `xfer_start_o` for exactly one cycle with x = word1[9:0], y = word1[24:16], width = word2[15:0], height = word2[31:16], and `xfer_read_o` high only for 0xC0.
- R9: After a 0xA0 setup, input words go straight to the transfer write port, under its ready signal, and are not parsed. This continues until `xfer_done_i` is sampled high. A word that handshakes in the same cycle as done still goes to the transfer engine.
- R10: While `pkt_valid_o` is high and `pkt_ready_i` is low, the output word and its last flag hold steady.
- R11: Reset clears all environment registers and the status word, drops every valid and start output, and leaves the input ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Input word valid |
| cmd_data_i | input | 32 | Input command word |
| cmd_ready_o | output | 1 | Input word accepted when high with valid |
| pkt_valid_o | output | 1 | Renderer word valid |
| pkt_data_o | output | 32 | Renderer word |
| pkt_last_o | output | 1 | Final word of the packet |
| pkt_ready_i | input | 1 | Renderer accepts the word |
| env_o | output | 256 | Environment registers, register k at bits [32k+31:32k] |
| status_o | output | 13 | Status bits derived from environment registers 1 and 6 |
| xfer_start_o | output | 1 | One-cycle transfer start pulse |
| xfer_read_o | output | 1 | Transfer direction, 1 = read |
| xfer_x_o | output | 10 | Rectangle x |
| xfer_y_o | output | 9 | Rectangle y |
| xfer_w_o | output | 16 | Rectangle width |
| xfer_h_o | output | 16 | Rectangle height |
| xfer_wvalid_o | output | 1 | Transfer write word valid |
| xfer_wdata_o | output | 32 | Transfer write word |
| xfer_wready_i | input | 1 | Transfer engine accepts a write word |
| xfer_done_i | input | 1 | Transfer engine finished the write |

## Verification
The last word of a write transfer and the engine's done indication can arrive in the same cycle. The bench provokes this by driving `xfer_done_i` high together with a valid data word while the write port is ready. It then sends an environment command straight after, with no idle cycle. A cycle-accurate model in the bench decides, cycle by cycle, whether each word belongs to the transfer or starts a new packet. The bench then compares the transfer port, the renderer port and the environment registers against that model.

// File: rtl/pp_pkg.sv
package pp_pkg;
  localparam int WORD_W = 32;

  typedef enum logic [1:0] {
    ST_COLLECT,
    ST_COMMIT,
    ST_EMIT,
    ST_BYPASS
  } pp_state_e;

  localparam logic [7:0] OP_VRAM_WR = 8'hA0;
  localparam logic [7:0] OP_VRAM_RD = 8'hC0;

  // extra words following the opcode word
  function automatic logic [3:0] extra_words(input logic [7:0] op);
    logic [3:0] n;
    n = 4'd0;
    case (op[7:4])
      4'h0: n = (op == 8'h02) ? 4'd2 : 4'd0;
      4'h2: case (op[3:2])
              2'd0: n = 4'd3;
              2'd1: n = 4'd6;
              2'd2: n = 4'd4;
              default: n = 4'd8;
            endcase
      4'h3: case (op[3:2])
              2'd0: n = 4'd5;
              2'd1: n = 4'd8;
              2'd2: n = 4'd7;
              default: n = 4'd11;
            endcase
      4'h4: n = (op[3:2] == 2'd0) ? 4'd2 : (op[3] ? 4'd3 : 4'd0);
      4'h5: n = (op[3:2] == 2'd0) ? 4'd3 : (op[3] ? 4'd4 : 4'd0);
      4'h6, 4'h7: case (op[3:2])
              2'd0: n = 4'd2;
              2'd1: n = 4'd3;
              2'd2: n = 4'd1;
              default: n = 4'd2;
            endcase
      4'h8: n = (op == 8'h80) ? 4'd3 : 4'd0;
      4'hA: n = (op == OP_VRAM_WR) ? 4'd2 : 4'd0;
      4'hC: n = (op == OP_VRAM_RD) ? 4'd2 : 4'd0;
      default: n = 4'd0;
    endcase
    return n;
  endfunction
endpackage

// File: rtl/pp_len_decode.sv
module pp_len_decode
  import pp_pkg::*;
#(
  parameter int LEN_W = 4
) (
  input  logic [7:0]       op_i,
  output logic [LEN_W-1:0] len_o,
  output logic             is_xfer_o,
  output logic             is_write_o
);
  always_comb begin
    len_o      = LEN_W'(extra_words(op_i)) + LEN_W'(1);
    is_xfer_o  = (op_i == OP_VRAM_WR) || (op_i == OP_VRAM_RD);
    is_write_o = (op_i == OP_VRAM_WR);
  end
endmodule

// File: rtl/pp_env_regs.sv
module pp_env_regs
  import pp_pkg::*;
#(
  parameter int NUM_ENV = 8
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      commit_i,
  input  logic [WORD_W-1:0]         word0_i,
  input  logic [WORD_W-1:0]         word4_i,
  input  logic [WORD_W-1:0]         word5_i,
  output logic [NUM_ENV*WORD_W-1:0] env_o,
  output logic [12:0]               status_o
);
  localparam int SEL_W = $clog2(NUM_ENV);

  logic [WORD_W-1:0] env_q [NUM_ENV];
  logic [WORD_W-1:0] env_d [NUM_ENV];
  logic [12:0]       status_q;
  logic [7:0]        op;

  assign op = word0_i[31:24];

  always_comb begin
    for (int i = 0; i < NUM_ENV; i++) env_d[i] = env_q[i];
    if (op[7:3] == 5'b11100) begin
      env_d[op[SEL_W-1:0]] = word0_i;
    end else if ((op & 8'hF4) == 8'h24) begin
      env_d[1][8:0] = word4_i[8:0];
    end else if ((op & 8'hF4) == 8'h34) begin
      env_d[1][8:0] = word5_i[8:0];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NUM_ENV; i++) env_q[i] <= '0;
      status_q <= '0;
    end else if (commit_i) begin
      for (int i = 0; i < NUM_ENV; i++) env_q[i] <= env_d[i];
      status_q <= {env_d[6][1:0], env_d[1][10:0]};
    end
  end

  for (genvar g = 0; g < NUM_ENV; g++) begin : g_flat
    assign env_o[g*WORD_W +: WORD_W] = env_q[g];
  end

  assign status_o = status_q;
endmodule

// File: rtl/pp_xfer_setup.sv
module pp_xfer_setup
  import pp_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              read_i,
  input  logic [WORD_W-1:0] pos_i,
  input  logic [WORD_W-1:0] size_i,
  output logic              start_o,
  output logic              read_o,
  output logic [9:0]        x_o,
  output logic [8:0]        y_o,
  output logic [15:0]       w_o,
  output logic [15:0]       h_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      start_o <= 1'b0;
      read_o  <= 1'b0;
      x_o     <= '0;
      y_o     <= '0;
      w_o     <= '0;
      h_o     <= '0;
    end else begin
      start_o <= load_i;
      if (load_i) begin
        read_o <= read_i;
        x_o    <= pos_i[9:0];
        y_o    <= pos_i[24:16];
        w_o    <= size_i[15:0];
        h_o    <= size_i[31:16];
      end
    end
  end
endmodule

// File: rtl/pkt_parser.sv
module pkt_parser
  import pp_pkg::*;
#(
  parameter int MAX_WORDS = 12,
  parameter int NUM_ENV   = 8
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      cmd_valid_i,
  input  logic [WORD_W-1:0]         cmd_data_i,
  output logic                      cmd_ready_o,
  output logic                      pkt_valid_o,
  output logic [WORD_W-1:0]         pkt_data_o,
  output logic                      pkt_last_o,
  input  logic                      pkt_ready_i,
  output logic [NUM_ENV*WORD_W-1:0] env_o,
  output logic [12:0]               status_o,
  output logic                      xfer_start_o,
  output logic                      xfer_read_o,
  output logic [9:0]                xfer_x_o,
  output logic [8:0]                xfer_y_o,
  output logic [15:0]               xfer_w_o,
  output logic [15:0]               xfer_h_o,
  output logic                      xfer_wvalid_o,
  output logic [WORD_W-1:0]         xfer_wdata_o,
  input  logic                      xfer_wready_i,
  input  logic                      xfer_done_i
);
  localparam int IDX_W = $clog2(MAX_WORDS);
  localparam int LEN_W = $clog2(MAX_WORDS + 1);

  pp_state_e         state_q, state_d;
  logic [WORD_W-1:0] buf_q [MAX_WORDS];
  logic [IDX_W-1:0]  cnt_q, emit_q;
  logic [LEN_W-1:0]  len_q;

  logic [7:0]        dec_op;
  logic [LEN_W-1:0]  dec_len, cur_len;
  logic              dec_xfer, dec_write;
  logic              accept, final_word, emit_fire, emit_last;
  logic              commit, env_commit, xfer_load;

  assign dec_op = (state_q == ST_COLLECT) ? cmd_data_i[31:24] : buf_q[0][31:24];

  pp_len_decode #(.LEN_W(LEN_W)) u_len (
    .op_i      (dec_op),
    .len_o     (dec_len),
    .is_xfer_o (dec_xfer),
    .is_write_o(dec_write)
  );

  assign accept     = (state_q == ST_COLLECT) && cmd_valid_i;
  assign cur_len    = (cnt_q == '0) ? dec_len : len_q;
  assign final_word = accept && ((LEN_W'(cnt_q) + LEN_W'(1)) == cur_len);
  assign commit     = (state_q == ST_COMMIT);
  assign env_commit = commit && !dec_xfer;
  assign xfer_load  = commit && dec_xfer;
  assign emit_last  = (LEN_W'(emit_q) + LEN_W'(1)) == len_q;
  assign emit_fire  = (state_q == ST_EMIT) && pkt_ready_i;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_COLLECT: if (final_word) state_d = ST_COMMIT;
      ST_COMMIT:  state_d = dec_xfer ? (dec_write ? ST_BYPASS : ST_COLLECT) : ST_EMIT;
      ST_EMIT:    if (emit_fire && emit_last) state_d = ST_COLLECT;
      ST_BYPASS:  if (xfer_done_i) state_d = ST_COLLECT;
      default:    state_d = ST_COLLECT;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_COLLECT;
      cnt_q   <= '0;
      emit_q  <= '0;
      len_q   <= LEN_W'(1);
    end else begin
      state_q <= state_d;
      if (accept) begin
        if (cnt_q == '0) len_q <= dec_len;
        cnt_q <= final_word ? '0 : cnt_q + IDX_W'(1);
      end
      if (commit) emit_q <= '0;
      else if (emit_fire && !emit_last) emit_q <= emit_q + IDX_W'(1);
    end
  end

  // payload storage needs no reset
  always_ff @(posedge clk_i) begin
    if (accept) buf_q[cnt_q] <= cmd_data_i;
  end

  pp_env_regs #(.NUM_ENV(NUM_ENV)) u_env (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .commit_i(env_commit),
    .word0_i (buf_q[0]),
    .word4_i (buf_q[4]),
    .word5_i (buf_q[5]),
    .env_o   (env_o),
    .status_o(status_o)
  );

  pp_xfer_setup u_xfer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (xfer_load),
    .read_i (!dec_write),
    .pos_i  (buf_q[1]),
    .size_i (buf_q[2]),
    .start_o(xfer_start_o),
    .read_o (xfer_read_o),
    .x_o    (xfer_x_o),
    .y_o    (xfer_y_o),
    .w_o    (xfer_w_o),
    .h_o    (xfer_h_o)
  );

  assign cmd_ready_o   = (state_q == ST_COLLECT) || ((state_q == ST_BYPASS) && xfer_wready_i);
  assign pkt_valid_o   = (state_q == ST_EMIT);
  assign pkt_data_o    = buf_q[emit_q];
  assign pkt_last_o    = (state_q == ST_EMIT) && emit_last;
  assign xfer_wvalid_o = (state_q == ST_BYPASS) && cmd_valid_i;
  assign xfer_wdata_o  = cmd_data_i;
endmodule

// File: rtl/pkt_parser_chk.sv
module pkt_parser_chk #(
  parameter int NUM_ENV = 8
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  cmd_ready_o,
  input logic                  pkt_valid_o,
  input logic [31:0]           pkt_data_o,
  input logic                  pkt_last_o,
  input logic                  pkt_ready_i,
  input logic [NUM_ENV*32-1:0] env_o,
  input logic [12:0]           status_o,
  input logic                  xfer_start_o,
  input logic                  xfer_wvalid_o
);
  // R10
  pkt_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pkt_valid_o && !pkt_ready_i |=> pkt_valid_o && $stable(pkt_data_o) && $stable(pkt_last_o));

  // R8
  start_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_start_o |=> !xfer_start_o);

  // R7
  status_track_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o == {env_o[6*32+1 -: 2], env_o[32+10 -: 11]});

  // R9
  no_mix_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(xfer_wvalid_o && pkt_valid_o));

  // R3
  no_accept_emit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(pkt_valid_o && cmd_ready_o));
endmodule

bind pkt_parser pkt_parser_chk #(.NUM_ENV(NUM_ENV)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .cmd_ready_o  (cmd_ready_o),
  .pkt_valid_o  (pkt_valid_o),
  .pkt_data_o   (pkt_data_o),
  .pkt_last_o   (pkt_last_o),
  .pkt_ready_i  (pkt_ready_i),
  .env_o        (env_o),
  .status_o     (status_o),
  .xfer_start_o (xfer_start_o),
  .xfer_wvalid_o(xfer_wvalid_o)
);

// File: tb/tb_pkt_parser.sv
module tb_pkt_parser;
  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         cmd_valid_i = 1'b0;
  logic [31:0]  cmd_data_i = '0;
  logic         cmd_ready_o;
  logic         pkt_valid_o;
  logic [31:0]  pkt_data_o;
  logic         pkt_last_o;
  logic         pkt_ready_i = 1'b1;
  logic [255:0] env_o;
  logic [12:0]  status_o;
  logic         xfer_start_o, xfer_read_o;
  logic [9:0]   xfer_x_o;
  logic [8:0]   xfer_y_o;
  logic [15:0]  xfer_w_o, xfer_h_o;
  logic         xfer_wvalid_o;
  logic [31:0]  xfer_wdata_o;
  logic         xfer_wready_i = 1'b1;
  logic         xfer_done_i = 1'b0;

  always #10 clk_i = ~clk_i;

  pkt_parser dut (.*);

  int checks = 0, errors = 0, cyc = 0;
  bit model_on = 0, stall_pkt = 0, stall_wr = 0, finished = 0;

  // reference model state
  int ph = 0, mcnt = 0, mlen = 1, memit = 0;
  logic [31:0] mbuf [16];
  logic [31:0] menv [8];
  int mstat = 0;
  bit mstart = 0, mrd = 0;
  int mx = 0, my = 0, mw = 0, mh = 0;

  function automatic int ext(int op);
    int t2[8] = '{3, 6, 4, 8, 5, 8, 7, 11};
    int t6[4] = '{2, 3, 1, 2};
    if (op == 2) return 2;
    if (op >= 'h20 && op <= 'h3F) return t2[(op >> 2) & 7];
    if (op >= 'h40 && op <= 'h43) return 2;
    if (op >= 'h48 && op <= 'h53) return 3;
    if (op >= 'h58 && op <= 'h5F) return 4;
    if (op >= 'h60 && op <= 'h7F) return t6[(op >> 2) & 3];
    if (op == 'h80) return 3;
    if (op == 'hA0 || op == 'hC0) return 2;
    return 0;
  endfunction

  task automatic chk(bit ok, string tag, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  initial for (int k = 0; k < 8; k++) menv[k] = '0;

  always @(negedge clk_i) begin
    cyc++;
    pkt_ready_i   = stall_pkt ? (cyc % 3 != 1) : 1'b1;
    xfer_wready_i = stall_wr ? (cyc % 4 != 2) : 1'b1;
  end

  // compare DUT to model shortly before each rising edge, then step the model
  always begin
    @(negedge clk_i);
    #8;
    if (model_on && !finished) begin
      bit exp_ready, nstart;
      int op;
      exp_ready = (ph == 0) || (ph == 3 && xfer_wready_i);
      chk(cmd_ready_o == exp_ready, (ph == 3) ? "R9 ready" : "R3 ready", cmd_ready_o, exp_ready);
      chk(pkt_valid_o == (ph == 2), "R3 pkt_valid", pkt_valid_o, ph == 2);
      if (ph == 2) begin
        chk(pkt_data_o == mbuf[memit], (mlen == 1) ? "R2 data" : "R1 data", pkt_data_o, mbuf[memit]);
        chk(pkt_last_o == (memit == mlen - 1), "R1 last", pkt_last_o, memit == mlen - 1);
      end
      chk(xfer_wvalid_o == (ph == 3 && cmd_valid_i), "R9 wvalid", xfer_wvalid_o, ph == 3 && cmd_valid_i);
      if (ph == 3 && cmd_valid_i) chk(xfer_wdata_o == cmd_data_i, "R9 wdata", xfer_wdata_o, cmd_data_i);
      chk(xfer_start_o == mstart, "R8 start", xfer_start_o, mstart);
      if (mstart) begin
        chk(xfer_read_o == mrd, "R8 dir", xfer_read_o, mrd);
        chk({xfer_x_o, xfer_y_o} == {10'(mx), 9'(my)}, "R8 xy", {xfer_x_o, xfer_y_o}, {10'(mx), 9'(my)});
        chk({xfer_w_o, xfer_h_o} == {16'(mw), 16'(mh)}, "R8 wh", {xfer_w_o, xfer_h_o}, {16'(mw), 16'(mh)});
      end
      for (int k = 0; k < 8; k++)
        chk(env_o[k*32 +: 32] == menv[k], "R4 env", env_o[k*32 +: 32], menv[k]);
      chk(status_o == 13'(mstat), "R7 status", status_o, mstat);

      nstart = 0;
      case (ph)
        0: if (cmd_valid_i) begin
             mbuf[mcnt] = cmd_data_i;
             if (mcnt == 0) mlen = 1 + ext(int'(cmd_data_i[31:24]));
             if (mcnt + 1 == mlen) begin ph = 1; mcnt = 0; end
             else mcnt++;
           end
        1: begin
             op = int'(mbuf[0][31:24]);
             if (op == 'hA0 || op == 'hC0) begin
               nstart = 1;
               mrd = (op == 'hC0);
               mx = int'(mbuf[1][9:0]);
               my = int'(mbuf[1][24:16]);
               mw = int'(mbuf[2][15:0]);
               mh = int'(mbuf[2][31:16]);
               ph = (op == 'hA0) ? 3 : 0;
             end else begin
               if (op >= 'hE0 && op <= 'hE7) menv[op & 7] = mbuf[0];
               else if ((op & 'hF4) == 'h24) menv[1] = (menv[1] & ~32'h1FF) | (mbuf[4] & 32'h1FF);
               else if ((op & 'hF4) == 'h34) menv[1] = (menv[1] & ~32'h1FF) | (mbuf[5] & 32'h1FF);
               mstat = int'(((menv[6] & 3) << 11) | (menv[1] & 'h7FF));
               ph = 2;
               memit = 0;
             end
           end
        2: if (pkt_ready_i) begin
             if (memit == mlen - 1) ph = 0;
             else memit++;
           end
        default: if (xfer_done_i) ph = 0;
      endcase
      mstart = nstart;
    end
  end

  // caller is at a falling edge; returns at the falling edge after the handshake
  task automatic send(logic [31:0] w);
    bit ok;
    cmd_valid_i = 1'b1;
    cmd_data_i  = w;
    ok = 0;
    while (!ok) begin
      #8;
      ok = cmd_ready_o;
      @(negedge clk_i);
    end
  endtask

  task automatic idle(int n);
    cmd_valid_i = 1'b0;
    repeat (n) @(negedge clk_i);
  endtask

  task automatic send_pkt(logic [7:0] op, int n, logic [31:0] seed);
    send({op, seed[23:0]});
    for (int i = 1; i < n; i++) send(seed + 32'(i) * 32'h0101_0101);
  endtask

  always @(posedge clk_i) begin
    if (!finished && cyc > 20000) begin
      finished = 1;
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    #8;
    // R11 reset state
    chk(pkt_valid_o == 0 && xfer_start_o == 0 && xfer_wvalid_o == 0, "R11 valids", pkt_valid_o, 0);
    chk(cmd_ready_o == 1, "R11 ready", cmd_ready_o, 1);
    chk(env_o == '0 && status_o == '0, "R11 regs", status_o, 0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    model_on = 1;

    // R2 single-word packets, R1 various lengths
    send(32'h0000_0011);
    send(32'h4400_0022);
    send_pkt(8'h20, 4, 32'h1000_0000);
    send_pkt(8'h02, 3, 32'h2000_0000);
    stall_pkt = 1;
    send_pkt(8'h3C, 12, 32'h3000_0000);
    send_pkt(8'h68, 2, 32'h4000_0000);
    send_pkt(8'h7C, 3, 32'h5000_0000);
    send_pkt(8'h80, 4, 32'h6000_0000);
    // R3 gaps inside a packet
    send(32'h2C00_0000);
    idle(3);
    for (int i = 1; i < 9; i++) begin send(32'h0700_0000 + 32'(i)); idle(2); end
    idle(12);
    stall_pkt = 0;

    // R4 environment writes
    send(32'hE100_07FF);
    send(32'hE600_0003);
    send(32'hE700_ABCD);
    idle(4);
    chk(env_o[32 +: 32] == 32'hE100_07FF, "R4 env1", env_o[32 +: 32], 32'hE100_07FF);
    chk(env_o[7*32 +: 32] == 32'hE700_ABCD, "R4 env7", env_o[7*32 +: 32], 32'hE700_ABCD);

    // R5 flat textured family patches env1[8:0] from word 4
    send(32'h2600_0000);
    for (int i = 1; i < 7; i++) send((i == 4) ? 32'hFFFF_FFA5 - 32'hFE00 : 32'h0000_0E00 + 32'(i));
    idle(12);
    chk(env_o[32 +: 32] == 32'hE100_07A5, "R5 texpage", env_o[32 +: 32], 32'hE100_07A5);
    chk(status_o == 13'h1FA5, "R7 status after R5", status_o, 13'h1FA5);

    // R6 shaded textured family uses word 5
    send(32'h3500_0000);
    for (int i = 1; i < 9; i++) send((i == 5) ? 32'h0000_3C12 : 32'h0000_01FF);
    idle(14);
    chk(env_o[32 +: 32] == 32'hE100_0612, "R6 texpage", env_o[32 +: 32], 32'hE100_0612);
    chk(status_o == 13'h1E12, "R7 status after R6", status_o, 13'h1E12);

    // R8 read setup, no forwarding, no bypass
    send(32'hC000_0000);
    send(32'h0123_0155);
    send(32'h0040_0020);
    send(32'hE200_1234);
    idle(4);

    // R9 write setup with stalls on the write port, done alone
    stall_wr = 1;
    send(32'hA000_0000);
    send(32'h01FF_03FF);
    send(32'hFFFF_0001);
    for (int i = 0; i < 5; i++) send(32'hE500_0000 + 32'(i));
    cmd_valid_i = 1'b0;
    xfer_done_i = 1'b1;
    @(negedge clk_i);
    xfer_done_i = 1'b0;
    stall_wr = 0;
    send(32'hE300_0042);

    // R9 final word and done in the same cycle, next word parsed at once
    send(32'hA000_0000);
    send(32'h0000_0010);
    send(32'h0002_0002);
    send(32'hE400_1111);
    xfer_done_i = 1'b1;
    send(32'hE400_2222);
    xfer_done_i = 1'b0;
    send(32'hE000_5555);
    idle(6);
    chk(env_o[4*32 +: 32] == 32'h0, "R9 bypass words not parsed", env_o[4*32 +: 32], 0);
    chk(env_o[0 +: 32] == 32'hE000_5555, "R9 word after done parsed", env_o[0 +: 32], 32'hE000_5555);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule